// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a fully associative store of recently used address translations. It sits between a processor address port and memory. A virtual address on the lookup port returns, in the same cycle, a hit or miss indication, the physical address and an execute-never flag. On a hit the physical address goes straight to memory, so no page-table fetch is needed.

Each entry carries a two-bit size code. The code selects one of four region sizes: 4 KB, 64 KB, 1 MB or 16 MB. It sets how many upper virtual address bits take part in the comparison and how many low bits pass through unchanged into the physical address. Mixed page sizes therefore share one structure, and a single entry covers a whole large region. A page-table walker outside this block loads entries through the fill port, and a single flush strobe invalidates the whole store.

Top module: `mps_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports miss, with a physical address of zero and the execute-never flag low.
- R2: Lookup is combinational. `lookupHit` and `lookupMiss` are always complementary, and miss is reported whenever no valid entry covers the virtual address.
- R3: Size code 0 (4 KB): physical bits [31:12] come from the entry and bits [11:0] come from the virtual address.
- R4: Size code 1 (64 KB): physical bits [31:16] come from the entry and bits [15:0] come from the virtual address.
- R5: Size code 2 (1 MB): physical bits [31:20] come from the entry and bits [19:0] come from the virtual address.
- R6: Size code 3 (16 MB): physical bits [31:24] come from the entry and bits [23:0] come from the virtual address.
- R7: On a hit `lookupXn` equals the flag stored with the matching entry. On a miss it is low and `lookupPa` is zero.
- R8: A fill becomes visible to lookups from the cycle after `fillEn` is sampled. Address bits below the page size in `fillVa` and `fillPa` have no effect.
- R9: A fill that matches no stored region is written at a round-robin pointer. The pointer starts at entry 0 and steps by one, wrapping after entry 31, so the 33rd distinct fill evicts the first.
- R10: A fill with the same size code and the same masked virtual region as a valid entry overwrites that entry and does not advance the pointer.
- R11: When several valid entries cover the lookup address, the lowest-numbered entry supplies the result.
- R12: A one-cycle `flushEn` invalidates every entry and returns the pointer to entry 0. A fill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVa | input | 32 | Virtual address to translate |
| lookupHit | output | 1 | A valid entry covers lookupVa |
| lookupMiss | output | 1 | No valid entry covers lookupVa |
| lookupPa | output | 32 | Translated physical address (zero on miss) |
| lookupXn | output | 1 | Execute-never flag of the hit entry |
| fillEn | input | 1 | Write a translation this cycle |
| fillVa | input | 32 | Virtual address of the region to load |
| fillPa | input | 32 | Physical base of the region |
| fillSize | input | 2 | Size code: 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| fillXn | input | 1 | Execute-never flag to store |
| flushEn | input | 1 | Invalidate all entries |

## Verification
The lookup path is driven with one region of each size. Each lookup address differs from the region base only in offset bits, so a wrong pass-through boundary for any single size code shows up as a wrong physical address. A 4 KB entry placed inside a 16 MB entry checks the lowest-index priority, and an address just past a 64 KB region checks that the comparison boundary is neither too wide nor too narrow. A refill of an already stored 1 MB region is followed by 33 distinct fills, and the eviction pattern that follows tells an overwrite-in-place apart from an allocation. A flush issued together with a fill shows that the flush has priority.

// File: rtl/mps_tlb_pkg.sv
package mps_tlb_pkg;
  localparam int ADDR_W    = 32;
  localparam int MIN_SHIFT = 12;
  localparam int TAG_W     = ADDR_W - MIN_SHIFT;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pageSize_e;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
  } tlbStrobe_t;

  // Tag bits that take part in a compare for a given region size
  function automatic logic [TAG_W-1:0] tagMask(pageSize_e sz);
    case (sz)
      PG_64K:  return {{(TAG_W-4){1'b1}},  4'h0};
      PG_1M:   return {{(TAG_W-8){1'b1}},  8'h00};
      PG_16M:  return {{(TAG_W-12){1'b1}}, 12'h000};
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/mps_tlb_dp.sv
module mps_tlb_dp
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tlbStrobe_t           strb,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [TAG_W-1:0]     fillTag,
  input  logic [TAG_W-1:0]     fillPtag,
  input  pageSize_e            fillSize,
  input  logic                 fillXn,
  input  logic [ADDR_W-1:0]    lookupVa,
  output logic [ENTRIES-1:0]   fillMatch,
  output logic                 hit,
  output logic [ADDR_W-1:0]    pa,
  output logic                 xn
);
  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   vtag [ENTRIES];
  logic [TAG_W-1:0]   ptag [ENTRIES];
  pageSize_e          psize [ENTRIES];
  logic [ENTRIES-1:0] xnBit;
  logic [ENTRIES-1:0] hitVec;
  logic [TAG_W-1:0]   lookTag;
  logic [IDX_W-1:0]   sel;
  logic [TAG_W-1:0]   selMask;

  assign lookTag = lookupVa[ADDR_W-1:MIN_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
    end else if (strb.clrAll) begin
      valid <= '0;
    end else if (strb.wrEn) begin
      valid[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strb.wrEn && !strb.clrAll && wrIdx == IDX_W'(i)) begin
        vtag[i]  <= fillTag;
        ptag[i]  <= fillPtag;
        psize[i] <= fillSize;
        xnBit[i] <= fillXn;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    logic [TAG_W-1:0] m;
    assign m            = tagMask(psize[g]);
    assign hitVec[g]    = valid[g] && (((lookTag ^ vtag[g]) & m) == '0);
    assign fillMatch[g] = valid[g] && (psize[g] == fillSize)
                          && (((fillTag ^ vtag[g]) & m) == '0);
  end

  // Lowest index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) sel = IDX_W'(i);
    end
  end

  assign hit     = |hitVec;
  assign selMask = tagMask(psize[sel]);

  always_comb begin
    if (hit) begin
      pa = {(ptag[sel] & selMask) | (lookTag & ~selMask),
            lookupVa[MIN_SHIFT-1:0]};
      xn = xnBit[sel];
    end else begin
      pa = '0;
      xn = 1'b0;
    end
  end
endmodule

// File: rtl/mps_tlb_ctrl.sv
module mps_tlb_ctrl
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic               flushEn,
  input  logic [ENTRIES-1:0] fillMatch,
  output tlbStrobe_t         strb,
  output logic [IDX_W-1:0]   wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic             anyMatch;

  assign anyMatch = |fillMatch;

  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatch[i]) matchIdx = IDX_W'(i);
    end
  end

  assign wrIdx       = anyMatch ? matchIdx : rrPtr;
  assign strb.clrAll = flushEn;
  assign strb.wrEn   = fillEn && !flushEn;

  always_ff @(posedge clk) begin
    if (!rstN || flushEn) begin
      rrPtr <= '0;
    end else if (fillEn && !anyMatch) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/mps_tlb.sv
module mps_tlb
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] lookupVa,
  output logic        lookupHit,
  output logic        lookupMiss,
  output logic [31:0] lookupPa,
  output logic        lookupXn,
  input  logic        fillEn,
  input  logic [31:0] fillVa,
  input  logic [31:0] fillPa,
  input  logic [1:0]  fillSize,
  input  logic        fillXn,
  input  logic        flushEn
);
  tlbStrobe_t         strb;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] fillMatch;
  logic               hit;
  logic               unusedLowBits;

  // Offset bits of a fill never reach storage
  assign unusedLowBits = ^{fillVa[MIN_SHIFT-1:0], fillPa[MIN_SHIFT-1:0]};

  mps_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fillEn   (fillEn),
    .flushEn  (flushEn),
    .fillMatch(fillMatch),
    .strb     (strb),
    .wrIdx    (wrIdx)
  );

  mps_tlb_dp #(.ENTRIES(ENTRIES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .fillTag  (fillVa[ADDR_W-1:MIN_SHIFT]),
    .fillPtag (fillPa[ADDR_W-1:MIN_SHIFT]),
    .fillSize (pageSize_e'(fillSize)),
    .fillXn   (fillXn),
    .lookupVa (lookupVa),
    .fillMatch(fillMatch),
    .hit      (hit),
    .pa       (lookupPa),
    .xn       (lookupXn)
  );

  assign lookupHit  = hit;
  assign lookupMiss = ~hit;
endmodule

// File: rtl/mps_tlb_chk.sv
module mps_tlb_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] lookupVa,
  input logic        lookupHit,
  input logic        lookupMiss,
  input logic [31:0] lookupPa,
  input logic        lookupXn,
  input logic        fillEn,
  input logic [31:0] fillVa,
  input logic        flushEn
);
  a_r1_reset_miss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> lookupMiss);

  a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit != lookupMiss);

  a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupPa[11:0] == lookupVa[11:0]);

  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    lookupMiss |-> (lookupPa == 32'h0 && !lookupXn));

  a_r8_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushEn) |=> (lookupVa != $past(fillVa) || lookupHit));

  a_r12_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> lookupMiss);
endmodule

bind mps_tlb mps_tlb_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lookupVa  (lookupVa),
  .lookupHit (lookupHit),
  .lookupMiss(lookupMiss),
  .lookupPa  (lookupPa),
  .lookupXn  (lookupXn),
  .fillEn    (fillEn),
  .fillVa    (fillVa),
  .flushEn   (flushEn)
);

// File: tb/mps_tlb_tb.sv
module mps_tlb_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [31:0] lookupVa, fillVa, fillPa, lookupPa;
  logic        fillEn, flushEn, fillXn;
  logic [1:0]  fillSize;
  logic        lookupHit, lookupMiss, lookupXn;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic        mValid [32];
  logic [31:0] mVa    [32];
  logic [31:0] mPa    [32];
  int          mSize  [32];
  logic        mXn    [32];
  int          mPtr;

  mps_tlb u_dut (
    .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .lookupHit(lookupHit),
    .lookupMiss(lookupMiss), .lookupPa(lookupPa), .lookupXn(lookupXn),
    .fillEn(fillEn), .fillVa(fillVa), .fillPa(fillPa), .fillSize(fillSize),
    .fillXn(fillXn), .flushEn(flushEn)
  );

  function automatic int shOf(int s);
    return 12 + 4 * s;
  endfunction

  function automatic logic covers(logic [31:0] a, logic [31:0] b, int s);
    return (a >> shOf(s)) == (b >> shOf(s));
  endfunction

  task automatic compare(string tag);
    logic        eHit = 1'b0;
    logic [31:0] ePa  = 32'h0;
    logic        eXn  = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (!eHit && mValid[i] && covers(lookupVa, mVa[i], mSize[i])) begin
        logic [31:0] low;
        low  = (32'h1 << shOf(mSize[i])) - 32'h1;
        eHit = 1'b1;
        ePa  = (mPa[i] & ~low) | (lookupVa & low);
        eXn  = mXn[i];
      end
    end
    checks++;
    if (lookupHit !== eHit || lookupMiss !== !eHit || lookupPa !== ePa || lookupXn !== eXn) begin
      errors++;
      $display("FAIL %s va=%h: actual hit=%0b miss=%0b pa=%h xn=%0b expected hit=%0b miss=%0b pa=%h xn=%0b",
               tag, lookupVa, lookupHit, lookupMiss, lookupPa, lookupXn, eHit, !eHit, ePa, eXn);
    end
  endtask

  task automatic modelUpdate(logic fe, logic [31:0] fv, logic [31:0] fp,
                             int fs, logic fx, logic fl);
    if (fl) begin
      for (int i = 0; i < 32; i++) mValid[i] = 1'b0;
      mPtr = 0;
    end else if (fe) begin
      int slot = -1;
      for (int i = 0; i < 32; i++)
        if (slot < 0 && mValid[i] && mSize[i] == fs && covers(fv, mVa[i], fs)) slot = i;
      if (slot < 0) begin
        slot = mPtr;
        mPtr = (mPtr + 1) % 32;
      end
      mValid[slot] = 1'b1; mVa[slot] = fv; mPa[slot] = fp;
      mSize[slot] = fs;    mXn[slot] = fx;
    end
  endtask

  task automatic cyc(string tag, logic [31:0] va, logic fe, logic [31:0] fv,
                     logic [31:0] fp, logic [1:0] fs, logic fx, logic fl);
    lookupVa = va; fillEn = fe; fillVa = fv; fillPa = fp;
    fillSize = fs; fillXn = fx; flushEn = fl;
    #1 compare(tag);
    @(posedge clk);
    modelUpdate(fe, fv, fp, int'(fs), fx, fl);
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [31:0] va);
    cyc(tag, va, 1'b0, 32'h0, 32'h0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic fill(string tag, logic [31:0] fv, logic [31:0] fp,
                      logic [1:0] fs, logic fx);
    cyc(tag, fv, 1'b1, fv, fp, fs, fx, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mValid[i] = 1'b0;
    mPtr = 0;
    rstN = 1'b0; lookupVa = 32'h0; fillEn = 1'b0; fillVa = 32'h0;
    fillPa = 32'h0; fillSize = 2'd0; fillXn = 1'b0; flushEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 compare("R1 in reset");
    rstN = 1'b1;
    look("R1", 32'h0001_2345);

    // One region of each size; offset passes through per size code
    fill("R8 fill cycle", 32'h0001_2345, 32'hABCD_E123, 2'd0, 1'b0);
    look("R3", 32'h0001_2FFF);
    fill("R8", 32'h0040_0000, 32'h1234_5678, 2'd1, 1'b0);
    look("R4", 32'h0040_ABCD);
    look("R2 past 64K", 32'h0041_0000);
    fill("R8", 32'h0500_0000, 32'h7710_0000, 2'd2, 1'b1);
    look("R5", 32'h050F_1234);
    look("R7 xn", 32'h0500_0000);
    fill("R8", 32'h8000_0000, 32'h4200_0000, 2'd3, 1'b0);
    look("R6", 32'h80AB_CDEF);

    // Nested 4K page at a higher index than the 16M region
    fill("R8", 32'h8000_1000, 32'h1111_1000, 2'd0, 1'b1);
    look("R11", 32'h8000_1010);

    // Refill of the 1M region: overwrite, pointer unchanged
    fill("R10", 32'h0508_0000, 32'h6600_0000, 2'd2, 1'b0);
    look("R10", 32'h0501_0000);
    look("R7 updated xn", 32'h0500_0004);

    // 32 distinct pages sweep the pointer round the store
    for (int k = 0; k < 32; k++)
      fill("R9", 32'h1000_0000 + 32'(k) * 32'h1000, 32'h2000_0000 + 32'(k) * 32'h1000,
           2'd0, 1'(k));
    look("R9 old evicted", 32'h0001_2345);
    look("R9 oldest new", 32'h1000_0ABC);
    fill("R9", 32'h1000_0000 + 32'd32 * 32'h1000, 32'h3000_0000, 2'd0, 1'b0);
    look("R9 evict oldest", 32'h1000_0ABC);
    look("R9 next kept", 32'h1000_1ABC);

    // Flush together with a fill: flush wins
    cyc("R12", 32'h1000_1ABC, 1'b1, 32'h3000_0000, 32'h5000_0000, 2'd0, 1'b0, 1'b1);
    look("R12 flushed", 32'h1000_1ABC);
    look("R12 fill dropped", 32'h3000_0000);
    fill("R12", 32'h3000_0000, 32'h5000_0000, 2'd3, 1'b0);
    look("R12 after flush", 32'h30FF_FFFF);
    look("R2", 32'h3100_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule